// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer with Grace Window

This block is a watchdog that counts pulses of a slow low-power time base (around 10 kHz). The slow clock arrives on `slow_tick` as a single-cycle enable in the system clock domain. A selectable prescaler divides the pulses and feeds a 6-bit counter. One timeout is 64 prescaled ticks. A 4-bit configuration value is captured while reset is held, and it selects one of two modes.

In reset-timer mode the counter starts by itself once reset is released. A timeout sets a flag and opens a grace window of 512 slow ticks. If software does not clear the counter within that window, the block drives a system reset and sets a sticky cause flag. Only power-on clears that flag.

In general-timer mode software starts and stops the counter. Each timeout sets the flag, can raise an interrupt, and counting continues.

Writes to the control register are accepted only after a two-byte unlock on a separate access port. The hardware zeroes the counter whenever the system enters or leaves idle or power-down. A timeout that occurs while the system is in a low-power state pulses a wake-up output.

The watchdog sequencer has four states:
- STOP: the counter is parked.
- COUNT: the counter is running.
- GRACE: the timeout has happened and the window is running.
- RESET: the system reset is asserted.

Its transitions are:
- STOP→COUNT, on reset-timer mode or on the run bit being set.
- COUNT→STOP, on the run bit being cleared in general-timer mode.
- COUNT→GRACE, on a timeout in reset-timer mode.
- GRACE→COUNT, on any counter clear.
- GRACE→RESET, when the window expires.
- RESET is left only by a reset.

The unlock sequencer has three states:
- LOCKED.
- KEY1: the first key has been seen.
- OPEN.

Its transitions are:
- LOCKED→KEY1, on byte AA hex.
- KEY1→OPEN, on byte 55 hex.
- KEY1→LOCKED, on any other byte (AA restarts in KEY1).
- OPEN→LOCKED, on a protected write, on window expiry or on any access byte other than AA (AA goes to KEY1).

Top module: `lp_watchdog`

## Requirements
- R1: The mode is captured from `cfg_mode` on every clock edge while reset is asserted. The value F hex selects general-timer mode. Every other value selects reset-timer mode.
- R2: The control register holds the prescale code in bits [2:0]. Codes 0 to 7 divide by 1, 4, 8, 16, 32, 64, 128 and 256. Counting `slow_tick` edges after a counter clear, the timeout flag is set on edge 64×divide and not before.
- R3: A timeout sets the timeout flag, control bit 5. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. `irq` is high exactly while the flag, `irq_en` and `glob_irq_en` are all high.
- R4: In reset-timer mode, `wdt_rst` asserts on the 512th slow tick after the timeout edge. A clear command at tick 511 or earlier returns the block to counting without asserting a reset. Once asserted, `wdt_rst` stays high until a reset.
- R5: A protected write with bit 6 set zeroes the counter and the prescaler on that edge. Bit 6 always reads as 0.
- R6: The reset-cause flag, control bit 3, is set when the block asserts `wdt_rst`. A system reset (`sys_rst_n`) leaves the flag unchanged, a power-on reset (`por_n`) clears it, and a protected write of 0 to the bit clears it.
- R7: Any change of `in_idle` or `in_pd` zeroes the counter and the prescaler on that edge, and leaves the grace window.
- R8: In reset-timer mode, the run bit (bit 7) and the run-in-power-down bit (bit 4) cannot be written and read as 0, and the counter runs without software action. With configuration 5 hex the counter and the grace window halt while idle or power-down is active. With any other reset-timer configuration they keep counting.
- R9: In general-timer mode, bit 7 starts and stops the count. During power-down the counter runs only if bit 4 is set. During idle it runs.
- R10: `wake` pulses for one cycle after a timeout edge at which idle or power-down is active. It stays low for a timeout outside those states.
- R11: A control write is accepted only on the 4 clock edges that follow the second unlock byte, and only the first such write is accepted. A wrong byte between the two keys cancels the sequence, and writes made while locked are dropped.
- R12: After power-on reset the control register reads 00 hex, and `irq`, `wake` and `wdt_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the reset-cause flag |
| cfg_mode | input | 4 | Mode configuration, captured during reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| acc_wr | input | 1 | Write strobe of the unlock access port |
| acc_data | input | 8 | Byte written to the unlock access port |
| ctl_wr | input | 1 | Write strobe of the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| irq_en | input | 1 | Local interrupt enable |
| glob_irq_en | input | 1 | Global interrupt enable |
| in_idle | input | 1 | System is in idle mode |
| in_pd | input | 1 | System is in power-down mode |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up pulse |
| wdt_rst | output | 1 | System reset request |

## Verification
The bench sweeps all eight prescale codes and checks the timeout flag one edge before and exactly on edge 64×divide. A wrong divide table or an off-by-one prescaler would move that edge.

The grace window is probed at its last edge in two ways: without a clear, the reset must appear on tick 512 and not on tick 511; with a clear on tick 511, no reset may appear. A window that is one tick short or long would either fire early or ignore the rescue.

The unlock is probed with a write on the fourth and on the fifth edge after the key, with a second write, and with a wrong middle byte. A window of the wrong length, or an unlock that stays open, would let a dropped write change the register.

Low-power entry and exit are placed partway through a count. A design that did not clear the counter on those edges would time out early. A design that ignored the halt rule for configuration 5 hex would time out during idle.

// File: rtl/lp_wdt_pkg.sv
package lp_wdt_pkg;

    typedef enum logic [1:0] {
        WS_STOP,
        WS_COUNT,
        WS_GRACE,
        WS_RESET
    } wdt_state_e;

    typedef enum logic [1:0] {
        UL_LOCKED,
        UL_KEY1,
        UL_OPEN
    } unl_state_e;

    // control register layout
    localparam int CTL_W  = 8;
    localparam int SEL_W  = 3;
    localparam int B_RUN  = 7;
    localparam int B_CLR  = 6;
    localparam int B_TF   = 5;
    localparam int B_RPD  = 4;
    localparam int B_RF   = 3;

    // prescale code -> divide ratio: 1, then powers of two from 4 upward
    function automatic int unsigned div_ratio(input int unsigned code);
        return (code == 0) ? 32'd1 : (32'd1 << (code + 1));
    endfunction

endpackage

// File: rtl/lp_wdt_unlock.sv
module lp_wdt_unlock
    import lp_wdt_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'hAA,
    parameter logic [7:0] KEY_B = 8'h55,
    parameter int         WIN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_wr,
    input  logic [7:0] acc_data,
    input  logic       ctl_wr,
    output logic       open
);
    localparam int WW = $clog2(WIN + 1);

    unl_state_e    state_q, state_d;
    logic [WW-1:0] win_q, win_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UL_LOCKED;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        unique case (state_q)
            UL_LOCKED: begin
                if (acc_wr && acc_data == KEY_A) state_d = UL_KEY1;
            end
            UL_KEY1: begin
                if (acc_wr) begin
                    if (acc_data == KEY_B) begin
                        state_d = UL_OPEN;
                        win_d   = WW'(WIN);
                    end else if (acc_data != KEY_A) begin
                        state_d = UL_LOCKED;
                    end
                end
            end
            UL_OPEN: begin
                if (acc_wr)
                    state_d = (acc_data == KEY_A) ? UL_KEY1 : UL_LOCKED;
                else if (ctl_wr || win_q == WW'(1))
                    state_d = UL_LOCKED;
                else
                    win_d = win_q - WW'(1);
            end
            default: state_d = UL_LOCKED;
        endcase
    end

    always_comb begin
        open = (state_q == UL_OPEN);
    end

    assert_open_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (open && ctl_wr) |=> !open);

endmodule

// File: rtl/lp_wdt_count.sv
module lp_wdt_count
    import lp_wdt_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int PS_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            en,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            tmo
);
    localparam int PRE_W = 1 << PS_W;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_last;
    logic             ptick;

    always_comb begin
        pre_last = PRE_W'(div_ratio(32'(sel)) - 32'd1);
        ptick    = en & tick & (pre_q == pre_last);
        tmo      = ptick & (cnt_q == '1) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (en && tick) begin
            pre_q <= ptick ? '0 : pre_q + PRE_W'(1);
            if (ptick) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && pre_q == '0));

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/lp_wdt_fsm.sv
module lp_wdt_fsm
    import lp_wdt_pkg::*;
#(
    parameter int GRACE = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timer_mode,
    input  logic run,
    input  logic tick,
    input  logic halt,
    input  logic clr,
    input  logic tmo,
    output logic cnt_en,
    output logic wdt_rst,
    output logic fire
);
    localparam int            GW   = $clog2(GRACE);
    localparam logic [GW-1:0] LAST = GW'(GRACE - 1);

    wdt_state_e    state_q, state_d;
    logic [GW-1:0] gcnt_q, gcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_STOP;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            gcnt_q  <= gcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        gcnt_d  = gcnt_q;
        unique case (state_q)
            WS_STOP: begin
                if (!timer_mode || run) state_d = WS_COUNT;
            end
            WS_COUNT: begin
                if (timer_mode && !run) begin
                    state_d = WS_STOP;
                end else if (!timer_mode && tmo) begin
                    state_d = WS_GRACE;
                    gcnt_d  = '0;
                end
            end
            WS_GRACE: begin
                if (clr) begin
                    state_d = WS_COUNT;
                end else if (tick && !halt) begin
                    if (gcnt_q == LAST) state_d = WS_RESET;
                    else                gcnt_d  = gcnt_q + GW'(1);
                end
            end
            WS_RESET: state_d = WS_RESET;
            default:  state_d = WS_STOP;
        endcase
    end

    always_comb begin
        cnt_en  = (state_q == WS_COUNT || state_q == WS_GRACE) && !halt;
        wdt_rst = (state_q == WS_RESET);
        fire    = (state_q == WS_GRACE) && !clr && tick && !halt && (gcnt_q == LAST);
    end

    assert_rst_from_grace_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> ($past(state_q) == WS_GRACE));

    assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> wdt_rst);

    assert_self_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_mode && state_q != WS_STOP) |=> (state_q != WS_STOP));

endmodule

// File: rtl/lp_watchdog.sv
module lp_watchdog
    import lp_wdt_pkg::*;
#(
    parameter int         CNT_W       = 6,
    parameter int         GRACE_TICKS = 512,
    parameter int         UNLOCK_WIN  = 4,
    parameter int         CFG_W       = 4,
    parameter logic [3:0] CFG_TIMER   = 4'hF,
    parameter logic [3:0] CFG_HALT    = 4'h5,
    parameter logic [7:0] KEY_A       = 8'hAA,
    parameter logic [7:0] KEY_B       = 8'h55
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic [CFG_W-1:0] cfg_mode,
    input  logic             slow_tick,
    input  logic             acc_wr,
    input  logic [7:0]       acc_data,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             irq_en,
    input  logic             glob_irq_en,
    input  logic             in_idle,
    input  logic             in_pd,
    output logic             irq,
    output logic             wake,
    output logic             wdt_rst
);
    logic             rst_n;
    logic [CFG_W-1:0] cfg_q;
    logic             timer_mode;
    logic [1:0]       lp_q;
    logic             lp_edge;
    logic             open, wr_ok, clr, halt;
    logic             tmo, cnt_en, fire;
    logic [SEL_W-1:0] sel_q;
    logic             run_q, rpd_q, tf_q, rf_q, wake_q;

    assign rst_n = por_n & sys_rst_n;

    // mode configuration follows the input only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_mode;
    end

    always_comb begin
        timer_mode = (cfg_q == CFG_W'(CFG_TIMER));
        lp_edge    = ({in_idle, in_pd} != lp_q);
        wr_ok      = ctl_wr & open;
        clr        = (wr_ok & ctl_wdata[B_CLR]) | lp_edge;
        if (timer_mode) halt = in_pd & ~rpd_q;
        else            halt = (cfg_q == CFG_W'(CFG_HALT)) & (in_idle | in_pd);
    end

    lp_wdt_unlock #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B),
        .WIN   (UNLOCK_WIN)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_data (acc_data),
        .ctl_wr   (ctl_wr),
        .open     (open)
    );

    lp_wdt_count #(
        .CNT_W (CNT_W),
        .PS_W  (SEL_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick),
        .en    (cnt_en),
        .clr   (clr),
        .sel   (sel_q),
        .tmo   (tmo)
    );

    lp_wdt_fsm #(
        .GRACE (GRACE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_mode (timer_mode),
        .run        (run_q),
        .tick       (slow_tick),
        .halt       (halt),
        .clr        (clr),
        .tmo        (tmo),
        .cnt_en     (cnt_en),
        .wdt_rst    (wdt_rst),
        .fire       (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_q   <= 2'b00;
            sel_q  <= '0;
            run_q  <= 1'b0;
            rpd_q  <= 1'b0;
            tf_q   <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            lp_q   <= {in_idle, in_pd};
            wake_q <= tmo & (in_idle | in_pd);
            if (wr_ok) begin
                sel_q <= ctl_wdata[SEL_W-1:0];
                if (timer_mode) begin
                    run_q <= ctl_wdata[B_RUN];
                    rpd_q <= ctl_wdata[B_RPD];
                end
            end
            if (tmo)                          tf_q <= 1'b1;
            else if (wr_ok && !ctl_wdata[B_TF]) tf_q <= 1'b0;
        end
    end

    // reset-cause flag survives every reset but power-on
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                         rf_q <= 1'b0;
        else if (fire)                      rf_q <= 1'b1;
        else if (wr_ok && !ctl_wdata[B_RF]) rf_q <= 1'b0;
    end

    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[SEL_W-1:0]     = sel_q;
        ctl_rdata[B_RF]          = rf_q;
        ctl_rdata[B_RPD]         = rpd_q;
        ctl_rdata[B_TF]          = tf_q;
        ctl_rdata[B_RUN]         = run_q;
        irq                      = tf_q & irq_en & glob_irq_en;
        wake                     = wake_q;
    end

    assert_rflag_on_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> rf_q);

    assert_flag_on_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> tf_q);

    assert_mode_bits_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_mode |-> (!run_q && !rpd_q));

    assert_wake_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

endmodule

// File: tb/lp_watchdog_bench.sv
module lp_watchdog_bench;

    logic       clk = 1'b1;
    logic       por_n = 1'b0, sys_rst_n = 1'b0;
    logic [3:0] cfg_mode = 4'hF;
    logic       slow_tick = 1'b1;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_data = 8'h00;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       irq_en = 1'b0, glob_irq_en = 1'b0;
    logic       in_idle = 1'b0, in_pd = 1'b0;
    logic       irq, wake, wdt_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lp_watchdog u_lp_watchdog (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cfg_mode(cfg_mode),
        .slow_tick(slow_tick), .acc_wr(acc_wr), .acc_data(acc_data),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .irq_en(irq_en), .glob_irq_en(glob_irq_en), .in_idle(in_idle),
        .in_pd(in_pd), .irq(irq), .wake(wake), .wdt_rst(wdt_rst)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [7:0] b);
        acc_wr = 1'b1; acc_data = b; cyc(1); acc_wr = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d; cyc(1); ctl_wr = 1'b0;
    endtask

    task automatic pwr(input logic [7:0] d);
        acc(8'hAA); acc(8'h55); ctl(d);
    endtask

    task automatic por(input logic [3:0] cfg);
        cfg_mode = cfg; por_n = 1'b0; sys_rst_n = 1'b0;
        cyc(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R12 reset state, general-timer configuration (R1)
        por(4'hF);
        chk("R12 ctl after por", ctl_rdata, 8'h00);
        chk("R12 irq", irq, 0);
        chk("R12 wake", wake, 0);
        chk("R12 wdt_rst", wdt_rst, 0);

        // R11 unlock rules
        ctl(8'h03);
        chk("R11 locked write dropped", ctl_rdata[2:0], 0);
        acc(8'hAA); acc(8'h55); cyc(3); ctl(8'h03);
        chk("R11 write on 4th edge", ctl_rdata[2:0], 3);
        acc(8'hAA); acc(8'h55); cyc(4); ctl(8'h05);
        chk("R11 write on 5th edge dropped", ctl_rdata[2:0], 3);
        acc(8'hAA); acc(8'h12); acc(8'h55); ctl(8'h05);
        chk("R11 wrong middle byte", ctl_rdata[2:0], 3);
        pwr(8'h01); ctl(8'h06);
        chk("R11 second write dropped", ctl_rdata[2:0], 1);

        // R1 timer mode: run bit writable
        pwr(8'h80);
        chk("R1 run bit writable in timer mode", ctl_rdata[7], 1);
        cyc(2);

        // R2 / R3 / R5 / R10 sweep over all prescale codes
        irq_en = 1'b1; glob_irq_en = 1'b1;
        for (int p = 0; p < 8; p++) begin
            int d;
            d = (p == 0) ? 1 : (1 << (p + 1));
            pwr(8'hC0 | 8'(p));
            chk("R5 clear bit reads 0", ctl_rdata[6], 0);
            cyc(64 * d - 1);
            chk("R2 no timeout before 64*div", ctl_rdata[5], 0);
            chk("R3 irq low before timeout", irq, 0);
            cyc(1);
            chk("R2 timeout at 64*div", ctl_rdata[5], 1);
            chk("R3 irq on timeout", irq, 1);
            chk("R10 no wake when active", wake, 0);
        end
        glob_irq_en = 1'b0; cyc(1);
        chk("R3 irq gated by global enable", irq, 0);
        ctl_wdata = 8'h00; cyc(1);
        glob_irq_en = 1'b1; irq_en = 1'b0; cyc(1);
        chk("R3 irq gated by local enable", irq, 0);

        // R5 clear mid-count restarts the interval
        pwr(8'hC0);
        cyc(40);
        pwr(8'hC0);
        cyc(63);
        chk("R5 clear postpones timeout", ctl_rdata[5], 0);
        cyc(1);
        chk("R5 timeout 64 after clear", ctl_rdata[5], 1);

        // R9 stop
        pwr(8'h40);
        cyc(200);
        chk("R9 stopped counter never times out", ctl_rdata[5], 0);

        // R9 power-down without run-in-pd, R7 wake-up clears
        pwr(8'hC0);
        cyc(30);
        in_pd = 1'b1;
        cyc(300);
        chk("R9 halted in power-down", ctl_rdata[5], 0);
        in_pd = 1'b0;
        cyc(64);
        chk("R7 wake edge cleared counter", ctl_rdata[5], 0);
        cyc(1);
        chk("R7 timeout 64 after wake", ctl_rdata[5], 1);

        // R9 run-in-pd, R7 entry clears, R10 wake pulse
        pwr(8'hD0);
        cyc(20);
        in_pd = 1'b1;
        cyc(64);
        chk("R7 pd entry cleared counter", ctl_rdata[5], 0);
        chk("R10 no early wake", wake, 0);
        cyc(1);
        chk("R9 counts in pd with bit4", ctl_rdata[5], 1);
        chk("R10 wake pulse", wake, 1);
        cyc(1);
        chk("R10 wake one cycle", wake, 0);
        in_pd = 1'b0;

        // R1 non-F value selects reset-timer mode
        por(4'hE);
        pwr(8'h80);
        chk("R1 cfg E ignores run bit", ctl_rdata[7], 0);

        // R8 / R4 / R6 reset-timer mode
        por(4'h0);
        pwr(8'hD0);
        chk("R8 run and rpd read 0", ctl_rdata, 8'h00);
        cyc(63);
        chk("R8 no early timeout", ctl_rdata[5], 0);
        cyc(1);
        chk("R8 self-running timeout", ctl_rdata[5], 1);
        cyc(511);
        chk("R4 no reset at tick 511", wdt_rst, 0);
        cyc(1);
        chk("R4 reset at tick 512", wdt_rst, 1);
        chk("R6 cause flag set", ctl_rdata[3], 1);
        cyc(50);
        chk("R4 reset held", wdt_rst, 1);
        sys_rst_n = 1'b0; cyc(2); sys_rst_n = 1'b1; cyc(1);
        chk("R6 sys reset releases wdt_rst", wdt_rst, 0);
        chk("R6 flag kept over sys reset", ctl_rdata[3], 1);
        pwr(8'h00);
        chk("R6 software clears flag", ctl_rdata[3], 0);

        // R4 rescue on the last tick
        pwr(8'h40);
        cyc(64);
        chk("R4 timeout before rescue", ctl_rdata[5], 1);
        cyc(508);
        pwr(8'h40);
        cyc(1);
        chk("R4 clear at tick 511 prevents reset", wdt_rst, 0);
        cyc(200);
        chk("R4 still counting after rescue", wdt_rst, 0);
        cyc(1200);
        chk("R4 later expiry resets", wdt_rst, 1);
        chk("R6 flag set again", ctl_rdata[3], 1);
        por(4'h3);
        chk("R6 power-on clears flag", ctl_rdata[3], 0);
        chk("R12 wdt_rst low after por", wdt_rst, 0);

        // R8 configuration 3 keeps counting in idle
        pwr(8'h40);
        cyc(10);
        in_idle = 1'b1;
        cyc(64);
        chk("R8 idle entry cleared counter", ctl_rdata[5], 0);
        cyc(1);
        chk("R8 cfg 3 counts in idle", ctl_rdata[5], 1);
        chk("R10 wake from idle", wake, 1);
        in_idle = 1'b0;

        // R8 configuration 5 halts in idle
        por(4'h5);
        pwr(8'h40);
        cyc(10);
        in_idle = 1'b1;
        cyc(400);
        chk("R8 cfg 5 halts in idle", ctl_rdata[5], 0);
        chk("R8 cfg 5 no reset in idle", wdt_rst, 0);
        in_idle = 1'b0;
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule